// File: doc/BRIEF.md
# Windowed Sequence Monitor

This block is a synthesizable, clocked monitor for one temporal rule: after a start condition, a signal `b` must appear somewhere inside a window of cycles, and, when the trailing stage is enabled, a signal `c` must then hold a fixed number of cycles after that `b`. The window is set by a lower bound and an upper bound. The upper bound may be left open. An open upper bound gives three forms: wait at least N cycles, wait at least one cycle, or wait at least zero cycles (so `b` may coincide with the start). The monitor produces a one-cycle pass or fail pulse for each evaluation and a busy flag while an evaluation is in flight.

Only one evaluation runs at a time. Start conditions that arrive while the monitor is busy are dropped. The caller forms the start condition itself, for example the AND of an antecedent and a first expression, or a constant high for a rule with no antecedent. A disable input and the synchronous reset both abandon the evaluation in progress without producing a verdict. The parameters are checked at elaboration. A negative bound, a closed window whose upper bound is below its lower bound, a closed window with a zero lower bound, and a trailing stage with a delay below one are all rejected.

Top module: `rng_seq_mon`

## Requirements
- R1: While `rst_i` is high at a rising edge, `busy_o`, `pass_o` and `fail_o` are all low in the following cycle.
- R2: A high `trig_i` at an edge where the monitor is idle starts an evaluation. `busy_o` is high after that edge, unless the evaluation completes at that same edge.
- R3: With a closed window [MIN_DLY:MAX_DLY], `b_i` is sampled at the edges MIN_DLY through MAX_DLY after the start edge, and the first high sample is the match. If there is no match by offset MAX_DLY, `fail_o` pulses in the cycle after that edge.
- R4: With an open window and MIN_DLY of two or more, `b_i` is sampled from offset MIN_DLY onward with no timeout. The monitor stays busy until `b_i` is seen.
- R5: With an open window and MIN_DLY equal to one, `b_i` is sampled from the first edge after the start edge onward.
- R6: With an open window and MIN_DLY equal to zero, a high `b_i` at the start edge is already the match. Otherwise sampling continues from the next edge with no timeout.
- R7: With the trailing stage enabled, `c_i` is sampled exactly TAIL_DLY edges after the match edge. A high `c_i` gives a pass pulse and a low `c_i` gives a fail pulse; either way the monitor returns to idle.
- R8: With the trailing stage disabled, the match edge itself gives a pass pulse and the monitor returns to idle.
- R9: A high `trig_i` at an edge where the monitor is busy has no effect. This includes the edge at which the monitor returns to idle.
- R10: A high `dis_i` at an edge returns the monitor to idle. That edge produces no pass or fail pulse.
- R11: `pass_o` and `fail_o` are registered. Each lasts one cycle per verdict and starts in the cycle after the deciding edge. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all sampling on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| dis_i | input | 1 | Abandon the current evaluation, no verdict |
| trig_i | input | 1 | Start condition, honoured only when idle |
| b_i | input | 1 | Signal searched for inside the window |
| c_i | input | 1 | Signal checked at the fixed trailing offset |
| fail_o | output | 1 | One-cycle fail verdict |
| pass_o | output | 1 | One-cycle pass verdict |
| busy_o | output | 1 | An evaluation is in progress |

## Verification
The properties assume that `rst_i` is applied before any verdict matters and that `dis_i` is a clean level sampled on the clock. They also assume that an open window without a trailing stage leaves the busy state only through `b_i` or an abort. The stimulus keeps `b_i` frequent enough that open windows resolve. It asserts `dis_i` and `rst_i` only sparsely, so evaluations reach their verdicts. It also includes long stretches of constant start and absent `b_i`, which drive the timeout, the dropped-start and the stuck-waiting paths on four monitors, one for each window kind.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WAIT_MIN = 3'd1,
      ST_CHECK    = 3'd2,
      ST_WAIT_FIX = 3'd3,
      ST_TAIL     = 3'd4
   } seq_st_e;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_LOAD = 2'd1,
      CNT_DEC  = 2'd2,
      CNT_CLR  = 2'd3
   } cnt_op_e;

endpackage

// File: rtl/rng_seq_cnt.sv
module rng_seq_cnt
   import rng_seq_pkg::*;
#(
   parameter int CW = 3
) (
   input  logic          clk_i,
   input  logic          clr_i,
   input  cnt_op_e       op_i,
   input  logic [CW-1:0] ld_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         cnt_q <= '0;
      end else begin
         case (op_i)
            CNT_LOAD: cnt_q <= ld_i;
            CNT_DEC:  cnt_q <= cnt_q - 1'b1;
            CNT_CLR:  cnt_q <= '0;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rng_seq_ctl.sv
module rng_seq_ctl
   import rng_seq_pkg::*;
#(
   parameter int MIN_DLY  = 2,
   parameter int MAX_DLY  = 4,
   parameter bit OPEN_END = 1'b0,
   parameter int TAIL_DLY = 2,
   parameter bit TAIL_EN  = 1'b1,
   parameter int CW       = 3
) (
   input  seq_st_e       st_i,
   input  logic          zero_i,
   input  logic          trig_i,
   input  logic          b_i,
   input  logic          c_i,
   output seq_st_e       nxt_o,
   output cnt_op_e       op_o,
   output logic [CW-1:0] ld_o,
   output logic          pass_o,
   output logic          fail_o
);

   localparam int SPAN    = OPEN_END ? 0 : (MAX_DLY - MIN_DLY);
   localparam int WAIT_LD = (MIN_DLY >= 2) ? (MIN_DLY - 2) : 0;
   localparam int FIX_LD  = (TAIL_DLY >= 2) ? (TAIL_DLY - 2) : 0;

   // action taken when b is found
   seq_st_e       m_nxt;
   cnt_op_e       m_op;
   logic [CW-1:0] m_ld;
   logic          m_pass;

   generate
      if (!TAIL_EN) begin : g_match_done
         assign m_nxt  = ST_IDLE;
         assign m_op   = CNT_CLR;
         assign m_ld   = '0;
         assign m_pass = 1'b1;
      end else if (TAIL_DLY == 1) begin : g_match_tail
         assign m_nxt  = ST_TAIL;
         assign m_op   = CNT_CLR;
         assign m_ld   = '0;
         assign m_pass = 1'b0;
      end else begin : g_match_fix
         assign m_nxt  = ST_WAIT_FIX;
         assign m_op   = CNT_LOAD;
         assign m_ld   = CW'(FIX_LD);
         assign m_pass = 1'b0;
      end
   endgenerate

   // action taken when an evaluation starts
   seq_st_e       s_nxt;
   cnt_op_e       s_op;
   logic [CW-1:0] s_ld;
   logic          s_pass;

   generate
      if (OPEN_END && MIN_DLY == 0) begin : g_start_zero
         assign s_nxt  = b_i ? m_nxt : ST_CHECK;
         assign s_op   = b_i ? m_op : CNT_CLR;
         assign s_ld   = b_i ? m_ld : '0;
         assign s_pass = b_i & m_pass;
      end else if (MIN_DLY == 1) begin : g_start_one
         assign s_nxt  = ST_CHECK;
         assign s_op   = CNT_LOAD;
         assign s_ld   = CW'(SPAN);
         assign s_pass = 1'b0;
      end else begin : g_start_wait
         assign s_nxt  = ST_WAIT_MIN;
         assign s_op   = CNT_LOAD;
         assign s_ld   = CW'(WAIT_LD);
         assign s_pass = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt_o  = st_i;
      op_o   = CNT_HOLD;
      ld_o   = '0;
      pass_o = 1'b0;
      fail_o = 1'b0;
      case (st_i)
         ST_IDLE: begin
            if (trig_i) begin
               nxt_o  = s_nxt;
               op_o   = s_op;
               ld_o   = s_ld;
               pass_o = s_pass;
            end
         end
         ST_WAIT_MIN: begin
            if (zero_i) begin
               nxt_o = ST_CHECK;
               op_o  = CNT_LOAD;
               ld_o  = CW'(SPAN);
            end else begin
               op_o = CNT_DEC;
            end
         end
         ST_CHECK: begin
            if (b_i) begin
               nxt_o  = m_nxt;
               op_o   = m_op;
               ld_o   = m_ld;
               pass_o = m_pass;
            end else if (!OPEN_END) begin
               if (zero_i) begin
                  nxt_o  = ST_IDLE;
                  fail_o = 1'b1;
               end else begin
                  op_o = CNT_DEC;
               end
            end
         end
         ST_WAIT_FIX: begin
            if (zero_i) nxt_o = ST_TAIL;
            else        op_o  = CNT_DEC;
         end
         ST_TAIL: begin
            nxt_o  = ST_IDLE;
            pass_o = c_i;
            fail_o = ~c_i;
         end
         default: nxt_o = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/rng_seq_mon.sv
module rng_seq_mon
   import rng_seq_pkg::*;
#(
   parameter int MIN_DLY  = 2,
   parameter int MAX_DLY  = 4,
   parameter bit OPEN_END = 1'b0,
   parameter int TAIL_DLY = 2,
   parameter bit TAIL_EN  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic dis_i,
   input  logic trig_i,
   input  logic b_i,
   input  logic c_i,
   output logic fail_o,
   output logic pass_o,
   output logic busy_o
);

   localparam int SPAN = OPEN_END ? 0 : (MAX_DLY - MIN_DLY);
   localparam int LIM1 = (SPAN > MIN_DLY) ? SPAN : MIN_DLY;
   localparam int LIM  = (LIM1 > TAIL_DLY) ? LIM1 : TAIL_DLY;
   localparam int CW   = $clog2(LIM + 2);

   generate
      if (MIN_DLY < 0 || (!OPEN_END && MAX_DLY < 0)) begin : g_err_neg
         $error("window bounds must not be negative");
      end
      if (!OPEN_END && MAX_DLY < MIN_DLY) begin : g_err_order
         $error("window upper bound is below its lower bound");
      end
      if (!OPEN_END && MIN_DLY == 0) begin : g_err_zero
         $error("closed window needs a lower bound of at least one");
      end
      if (TAIL_EN && TAIL_DLY < 1) begin : g_err_tail
         $error("trailing delay must be at least one");
      end
   endgenerate

   seq_st_e       st_q;
   seq_st_e       st_nxt;
   cnt_op_e       cnt_op;
   logic [CW-1:0] cnt_ld;
   logic          cnt_zero;
   logic          pass_evt;
   logic          fail_evt;
   logic          abort;
   logic          pass_q;
   logic          fail_q;

   assign abort = rst_i | dis_i;

   rng_seq_ctl #(
      .MIN_DLY (MIN_DLY),
      .MAX_DLY (MAX_DLY),
      .OPEN_END(OPEN_END),
      .TAIL_DLY(TAIL_DLY),
      .TAIL_EN (TAIL_EN),
      .CW      (CW)
   ) ctl_i (
      .st_i  (st_q),
      .zero_i(cnt_zero),
      .trig_i(trig_i),
      .b_i   (b_i),
      .c_i   (c_i),
      .nxt_o (st_nxt),
      .op_o  (cnt_op),
      .ld_o  (cnt_ld),
      .pass_o(pass_evt),
      .fail_o(fail_evt)
   );

   rng_seq_cnt #(
      .CW(CW)
   ) cnt_i (
      .clk_i (clk_i),
      .clr_i (abort),
      .op_i  (cnt_op),
      .ld_i  (cnt_ld),
      .zero_o(cnt_zero)
   );

   always_ff @(posedge clk_i) begin
      if (abort) begin
         st_q   <= ST_IDLE;
         pass_q <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         st_q   <= st_nxt;
         pass_q <= pass_evt;
         fail_q <= fail_evt;
      end
   end

   assign pass_o = pass_q;
   assign fail_o = fail_q;
   assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/rng_seq_mon_chk.sv
module rng_seq_mon_chk #(
   parameter int MIN_DLY  = 2,
   parameter bit OPEN_END = 1'b0,
   parameter bit TAIL_EN  = 1'b1
) (
   input logic clk_i,
   input logic rst_i,
   input logic dis_i,
   input logic b_i,
   input logic fail_o,
   input logic pass_o,
   input logic busy_o
);

   AST_VERDICT_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
      !(pass_o && fail_o)); // R11

   AST_FAIL_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      fail_o |=> !fail_o); // R11

   AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      dis_i |=> (!busy_o && !pass_o && !fail_o)); // R10

   AST_FAIL_FROM_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
      fail_o |-> $past(busy_o)); // R3

   generate
      if (!(OPEN_END && MIN_DLY == 0 && !TAIL_EN)) begin : g_pass_cause
         AST_PASS_FROM_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
            pass_o |-> $past(busy_o)); // R8
      end
      if (OPEN_END && !TAIL_EN) begin : g_open_hold
         AST_OPEN_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
            (busy_o && !b_i && !dis_i) |=> busy_o); // R4
      end
   endgenerate

endmodule

bind rng_seq_mon rng_seq_mon_chk #(
   .MIN_DLY (MIN_DLY),
   .OPEN_END(OPEN_END),
   .TAIL_EN (TAIL_EN)
) u_chk (
   .clk_i (clk_i),
   .rst_i (rst_i),
   .dis_i (dis_i),
   .b_i   (b_i),
   .fail_o(fail_o),
   .pass_o(pass_o),
   .busy_o(busy_o)
);

// File: tb/rng_seq_mon_tb.sv
module rng_seq_mon_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 4;

   // lane 0: closed [2:4] + tail 2; lane 1: open [3:$] no tail;
   // lane 2: open [1:$] + tail 1;   lane 3: open [0:$] + tail 3
   localparam int L_MIN [NL] = '{2, 3, 1, 0};
   localparam int L_MAX [NL] = '{4, 0, 0, 0};
   localparam bit L_OPEN[NL] = '{1'b0, 1'b1, 1'b1, 1'b1};
   localparam int L_K   [NL] = '{2, 1, 1, 3};
   localparam bit L_TEN [NL] = '{1'b1, 1'b0, 1'b1, 1'b1};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dis = 1'b0;
   logic trig = 1'b0;
   logic b = 1'b0;
   logic c = 1'b0;

   logic [NL-1:0] pass_w;
   logic [NL-1:0] fail_w;
   logic [NL-1:0] busy_w;

   int    n_chk = 0;
   int    n_err = 0;
   bit    armed = 1'b0;
   bit    done = 1'b0;
   string phase = "R1 reset";

   always #(CLK_PERIOD / 2) clk = ~clk;

   for (genvar g = 0; g < NL; g++) begin : g_lane
      rng_seq_mon #(
         .MIN_DLY (L_MIN[g]),
         .MAX_DLY (L_MAX[g]),
         .OPEN_END(L_OPEN[g]),
         .TAIL_DLY(L_K[g]),
         .TAIL_EN (L_TEN[g])
      ) dut_i (
         .clk_i (clk),
         .rst_i (rst),
         .dis_i (dis),
         .trig_i(trig),
         .b_i   (b),
         .c_i   (c),
         .fail_o(fail_w[g]),
         .pass_o(pass_w[g]),
         .busy_o(busy_w[g])
      );
   end

   // reference model: timestamps instead of counters
   int cyc = 0;
   bit act [NL];
   bit ph  [NL];
   int t0  [NL];
   int tm  [NL];
   bit ep  [NL];
   bit ef  [NL];
   bit eb  [NL];

   function automatic bit in_window(int l, int d);
      return (d >= L_MIN[l]) && (L_OPEN[l] || d <= L_MAX[l]);
   endfunction

   function automatic bit window_over(int l, int d);
      return !L_OPEN[l] && d >= L_MAX[l];
   endfunction

   function automatic string lane_tag(int l);
      case (l)
         0:       return "R3 R7";
         1:       return "R4 R8";
         2:       return "R5 R7";
         default: return "R6 R7";
      endcase
   endfunction

   always @(posedge clk) begin
      for (int l = 0; l < NL; l++) begin
         ep[l] = 1'b0;
         ef[l] = 1'b0;
         if (rst || dis) begin
            act[l] = 1'b0;
         end else begin
            if (!act[l] && trig) begin
               act[l] = 1'b1;
               ph[l]  = 1'b0;
               t0[l]  = cyc;
            end
            if (act[l] && !ph[l]) begin
               if (in_window(l, cyc - t0[l]) && b) begin
                  if (L_TEN[l]) begin
                     ph[l] = 1'b1;
                     tm[l] = cyc;
                  end else begin
                     ep[l]  = 1'b1;
                     act[l] = 1'b0;
                  end
               end else if (window_over(l, cyc - t0[l])) begin
                  ef[l]  = 1'b1;
                  act[l] = 1'b0;
               end
            end else if (act[l] && ph[l]) begin
               if (cyc - tm[l] == L_K[l]) begin
                  if (c) ep[l] = 1'b1;
                  else   ef[l] = 1'b1;
                  act[l] = 1'b0;
               end
            end
         end
         eb[l] = act[l];
      end
      cyc = cyc + 1;
      armed = 1'b1;
   end

   task automatic chk(input logic actv, input bit expv, input int l, input string what);
      n_chk++;
      if (actv !== expv) begin
         n_err++;
         $display("FAIL [%s] lane%0d [%s] %s act=%b exp=%b at %0t",
                  phase, l, lane_tag(l), what, actv, expv, $time);
      end
   endtask

   always @(negedge clk) begin
      if (armed && !done) begin
         for (int l = 0; l < NL; l++) begin
            chk(pass_w[l], ep[l], l, "pass");
            chk(fail_w[l], ef[l], l, "fail");
            chk(busy_w[l], eb[l], l, "busy");
            // R11: verdicts are exclusive
            chk(pass_w[l] & fail_w[l], 1'b0, l, "R11 pass&fail");
         end
      end
   end

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      // R1: reset state
      phase = "R1 reset";
      rst = 1'b1;
      trig = 1'b1;
      b = 1'b1;
      step(4);
      rst = 1'b0;
      trig = 1'b0;
      b = 1'b0;
      step(2);

      // R2 start, window match, tail sample
      phase = "R2 start";
      trig = 1'b1;
      step(1);
      trig = 1'b0;
      step(2);
      b = 1'b1;
      step(1);
      b = 1'b0;
      c = 1'b1;
      step(6);
      c = 1'b0;
      // zero-offset match for the open [0:$] lane (R6)
      trig = 1'b1;
      b = 1'b1;
      step(1);
      trig = 1'b0;
      b = 1'b0;
      step(8);

      // R9: start held high with b absent; closed window times out, open ones wait
      phase = "R9 busy-ignore";
      trig = 1'b1;
      step(14);
      b = 1'b1;
      step(1);
      b = 1'b0;
      trig = 1'b0;
      step(6);

      // R10: abort in the middle of an evaluation
      phase = "R10 abort";
      trig = 1'b1;
      step(1);
      trig = 1'b0;
      step(2);
      dis = 1'b1;
      b = 1'b1;
      step(1);
      dis = 1'b0;
      b = 1'b0;
      step(4);

      // R11 and all window kinds: constrained random traffic
      phase = "R11 random";
      for (int i = 0; i < 3000; i++) begin
         rst  = ($urandom % 400) == 0;
         dis  = ($urandom % 40) == 0;
         trig = ($urandom % 3) == 0;
         b    = ($urandom % 5) < 2;
         c    = ($urandom % 2) == 1;
         step(1);
      end
      rst = 1'b0;
      dis = 1'b0;
      trig = 1'b0;
      b = 1'b1;
      step(10);
      report();
   end

endmodule